// File: doc/BRIEF.md
# Two-Channel Edge-Programmable Up/Down Counter

The unit counts pulses from two channels into one shared signed counter. Each channel has a signal input and a control input. All four inputs are synchronized and pass through per-input glitch filters. A rising or a falling edge on a channel's filtered signal adds a step of +1, -1 or 0 to the counter. The step comes from a 2-bit action code, and the channel's control level can keep that step, reverse it or block it. With these codes the unit decodes quadrature encoders, direction-plus-step drives and plain event streams without changes to the wiring.

Each glitch filter is a four-state machine, declared as an enum with the states `FLT_STEADY_LO`, `FLT_RISE_WAIT`, `FLT_STEADY_HI` and `FLT_FALL_WAIT`. It has five transitions:
- *first-difference*: a steady state sees the opposite input level and moves to its wait state.
- *abandon*: a wait state sees the input return to the old level and goes back to the steady state.
- *extend*: a wait state sees the new level again, but the run is still shorter than the threshold, so the run counter is incremented.
- *confirm*: the run reaches the threshold and the machine moves to the opposite steady state. When the threshold is 0 or 1, a steady state confirms directly.
- *bypass*: while the filter is disabled, the state follows the synchronized input every cycle.

The counter compares its next value against a high limit, a low limit and two thresholds, and it also detects a return to zero. Reaching a limit returns the counter to zero and sets a sticky flag. The zero and threshold comparators emit one-cycle pulses.

Top module: `pulse_counter_unit`

## Requirements
- R1: The 32-bit configuration register resets to 0x3C10 and loads `cfg_wdata` on a clock with `cfg_we` high. Its fields are:
  - [9:0] filter threshold
  - [10] filter enable
  - [11] zero-compare enable
  - [12] high-limit enable
  - [13] low-limit enable
  - [14] threshold-0 enable
  - [15] threshold-1 enable
  - [23:16] channel 0 byte
  - [31:24] channel 1 byte

  Within each channel byte, bits [1:0] are the falling-edge action, [3:2] the rising-edge action, [5:4] the modifier used while control is high, and [7:6] the modifier used while control is low.
- R2: Action code 1 gives a step of +1, code 2 gives -1, and codes 0 and 3 give no step.
- R3: Modifier code 0 keeps the step, code 1 negates it, and codes 2 and 3 block it. The modifier is chosen by the filtered control level.
- R4: Steps from both channels in the same cycle are summed (net +2, -2 or 0). With the filter disabled, the counter reflects an input edge on the fourth rising clock edge after the input changes.
- R5: With the filter enabled, a level that holds for fewer than the threshold number of cycles is discarded, and one that holds for at least the threshold is accepted. A threshold of 0 behaves like 1.
- R6: With the filter disabled, a one-cycle input pulse is counted whatever the threshold value.
- R7: If the high limit is enabled and a nonzero net step would make the counter greater than or equal to the high limit, the counter becomes 0 and the high flag is set.
- R8: If the low limit is enabled and a nonzero net step would make the counter less than or equal to the low limit, the counter becomes 0 and the low flag is set.
- R9: The high and low flags stay set until `flag_clr[0]` or `flag_clr[1]` respectively is high on a clock. A set in the same cycle as a clear takes priority.
- R10: Each zero, threshold-0 or threshold-1 pulse lasts one cycle. It is issued, if its comparator is enabled, in the cycle the counter changes onto 0, `thresh0` or `thresh1` respectively.
- R11: `count_clr` forces the counter to 0 and takes priority over any step or limit event in that cycle.
- R12: A disabled comparator produces no flag or pulse. With a limit disabled, the counter passes that limit value and wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_wdata | input | 32 | Configuration value to load |
| cfg_q | output | 32 | Current configuration |
| sig_in | input | 2 | Signal input per channel |
| ctl_in | input | 2 | Control input per channel |
| high_limit | input | 16 | Signed high limit |
| low_limit | input | 16 | Signed low limit |
| thresh0 | input | 16 | Signed threshold 0 |
| thresh1 | input | 16 | Signed threshold 1 |
| count_clr | input | 1 | Synchronous counter clear |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 high flag, bit 1 low flag |
| count_o | output | 16 | Signed counter value |
| hi_flag | output | 1 | Sticky high-limit flag |
| lo_flag | output | 1 | Sticky low-limit flag |
| zero_pulse | output | 1 | Counter arrived at zero |
| thr0_pulse | output | 1 | Counter arrived at threshold 0 |
| thr1_pulse | output | 1 | Counter arrived at threshold 1 |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the two channels' steps. Pulses driven at the same instant on both signal inputs reach the counter in one cycle, and the bench judges the net +2 or 0 against hand-computed values.

The second pair is a limit-reaching step and a counter clear, or a limit-reaching step and a flag clear. The bench holds `count_clr` or `flag_clr` across the cycle in which a limit is met. A cycle-by-cycle behavioural model decides which one wins, and its verdict is compared with the outputs on every clock.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    localparam int FLT_THR_W = 10;

    typedef enum logic [1:0] {
        FLT_STEADY_LO = 2'd0,
        FLT_RISE_WAIT = 2'd1,
        FLT_STEADY_HI = 2'd2,
        FLT_FALL_WAIT = 2'd3
    } flt_state_e;

    // per-channel byte, msb first: low-ctl modifier, high-ctl modifier, rise action, fall action
    typedef struct packed {
        logic [1:0] lo_mod;
        logic [1:0] hi_mod;
        logic [1:0] rise_act;
        logic [1:0] fall_act;
    } chan_cfg_t;

    typedef struct packed {
        chan_cfg_t              ch1;
        chan_cfg_t              ch0;
        logic                   thr1_en;
        logic                   thr0_en;
        logic                   lo_en;
        logic                   hi_en;
        logic                   zero_en;
        logic                   flt_en;
        logic [FLT_THR_W-1:0]   flt_thr;
    } unit_cfg_t;

endpackage

// File: rtl/pcnt_sync.sv
module pcnt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pcnt_glitch_filter.sv
module pcnt_glitch_filter
    import pcnt_pkg::*;
#(
    parameter int THR_W = FLT_THR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [THR_W-1:0] thr,
    input  logic             raw,
    output logic             level
);
    flt_state_e       state_q, state_d;
    logic [THR_W-1:0] run_q, run_d;
    logic [THR_W-1:0] thr_eff;
    logic             reached;

    assign thr_eff = (thr == '0) ? THR_W'(1) : thr;
    assign reached = ({1'b0, run_q} + (THR_W+1)'(1)) >= {1'b0, thr_eff};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STEADY_LO;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (!en) begin
            state_d = raw ? FLT_STEADY_HI : FLT_STEADY_LO;   // bypass
            run_d   = '0;
        end else begin
            unique case (state_q)
                FLT_STEADY_LO: begin
                    if (raw) begin
                        if (thr_eff == THR_W'(1)) begin
                            state_d = FLT_STEADY_HI;         // confirm
                            run_d   = '0;
                        end else begin
                            state_d = FLT_RISE_WAIT;         // first-difference
                            run_d   = THR_W'(1);
                        end
                    end
                end
                FLT_RISE_WAIT: begin
                    if (!raw) begin
                        state_d = FLT_STEADY_LO;             // abandon
                        run_d   = '0;
                    end else if (reached) begin
                        state_d = FLT_STEADY_HI;             // confirm
                        run_d   = '0;
                    end else begin
                        run_d   = run_q + THR_W'(1);         // extend
                    end
                end
                FLT_STEADY_HI: begin
                    if (!raw) begin
                        if (thr_eff == THR_W'(1)) begin
                            state_d = FLT_STEADY_LO;
                            run_d   = '0;
                        end else begin
                            state_d = FLT_FALL_WAIT;
                            run_d   = THR_W'(1);
                        end
                    end
                end
                FLT_FALL_WAIT: begin
                    if (raw) begin
                        state_d = FLT_STEADY_HI;
                        run_d   = '0;
                    end else if (reached) begin
                        state_d = FLT_STEADY_LO;
                        run_d   = '0;
                    end else begin
                        run_d   = run_q + THR_W'(1);
                    end
                end
                default: begin
                    state_d = FLT_STEADY_LO;
                    run_d   = '0;
                end
            endcase
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            FLT_STEADY_HI, FLT_FALL_WAIT: level = 1'b1;
            default:                      level = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcnt_edge_decode.sv
module pcnt_edge_decode
    import pcnt_pkg::*;
(
    input  logic              lvl,
    input  logic              lvl_prev,
    input  logic              ctl,
    input  chan_cfg_t         ccfg,
    output logic signed [1:0] step
);
    logic [1:0]        act;
    logic [1:0]        modc;
    logic signed [1:0] base;

    always_comb begin
        if (lvl && !lvl_prev)      act = ccfg.rise_act;
        else if (!lvl && lvl_prev) act = ccfg.fall_act;
        else                       act = 2'd0;

        unique case (act)
            2'd1:    base = 2'sd1;
            2'd2:    base = -2'sd1;
            default: base = 2'sd0;
        endcase

        modc = ctl ? ccfg.hi_mod : ccfg.lo_mod;
        unique case (modc)
            2'd0:    step = base;
            2'd1:    step = -base;
            default: step = 2'sd0;
        endcase
    end
endmodule

// File: rtl/pulse_counter_unit.sv
module pulse_counter_unit
    import pcnt_pkg::*;
#(
    parameter int          CNT_W       = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] CFG_RST     = 32'h0000_3C10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_q,
    input  logic [1:0]              sig_in,
    input  logic [1:0]              ctl_in,
    input  logic signed [CNT_W-1:0] high_limit,
    input  logic signed [CNT_W-1:0] low_limit,
    input  logic signed [CNT_W-1:0] thresh0,
    input  logic signed [CNT_W-1:0] thresh1,
    input  logic                    count_clr,
    input  logic [1:0]              flag_clr,
    output logic signed [CNT_W-1:0] count_o,
    output logic                    hi_flag,
    output logic                    lo_flag,
    output logic                    zero_pulse,
    output logic                    thr0_pulse,
    output logic                    thr1_pulse
);
    localparam int N_CH  = 2;
    localparam int N_IN  = 2 * N_CH;
    localparam int SUM_W = CNT_W + 2;

    unit_cfg_t cfg_r;
    chan_cfg_t chcfg [N_CH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_r <= unit_cfg_t'(CFG_RST);
        else if (cfg_we) cfg_r <= unit_cfg_t'(cfg_wdata);
    end
    assign cfg_q    = cfg_r;
    assign chcfg[0] = cfg_r.ch0;
    assign chcfg[1] = cfg_r.ch1;

    // inputs 0..N_CH-1 are signals, N_CH..N_IN-1 are controls
    logic [N_IN-1:0] raw_in, synced, lvl;
    assign raw_in = {ctl_in, sig_in};

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_in
            pcnt_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .d(raw_in[i]), .q(synced[i])
            );
            pcnt_glitch_filter #(.THR_W(FLT_THR_W)) u_flt (
                .clk(clk), .rst_n(rst_n), .en(cfg_r.flt_en), .thr(cfg_r.flt_thr),
                .raw(synced[i]), .level(lvl[i])
            );
        end
    endgenerate

    logic [N_CH-1:0]   sig_prev;
    logic signed [1:0] step [N_CH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_prev <= '0;
        else        sig_prev <= lvl[N_CH-1:0];
    end

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            pcnt_edge_decode u_dec (
                .lvl(lvl[c]), .lvl_prev(sig_prev[c]), .ctl(lvl[N_CH+c]),
                .ccfg(chcfg[c]), .step(step[c])
            );
        end
    endgenerate

    logic signed [2:0]       net;
    logic signed [SUM_W-1:0] sum_w, hi_ext, lo_ext;
    logic                    moving, hit_hi, hit_lo, changed;
    logic signed [CNT_W-1:0] cnt_q, cnt_d;

    assign net    = {step[0][1], step[0]} + {step[1][1], step[1]};
    assign moving = (net != 3'sd0);
    assign sum_w  = {{2{cnt_q[CNT_W-1]}}, cnt_q} + {{(SUM_W-3){net[2]}}, net};
    assign hi_ext = {{2{high_limit[CNT_W-1]}}, high_limit};
    assign lo_ext = {{2{low_limit[CNT_W-1]}}, low_limit};
    assign hit_hi = !count_clr && moving && cfg_r.hi_en && (sum_w >= hi_ext);
    assign hit_lo = !count_clr && moving && cfg_r.lo_en && !hit_hi && (sum_w <= lo_ext);

    always_comb begin
        if (count_clr)            cnt_d = '0;
        else if (hit_hi || hit_lo) cnt_d = '0;
        else if (moving)          cnt_d = sum_w[CNT_W-1:0];
        else                      cnt_d = cnt_q;
    end
    assign changed = (cnt_d != cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            hi_flag    <= 1'b0;
            lo_flag    <= 1'b0;
            zero_pulse <= 1'b0;
            thr0_pulse <= 1'b0;
            thr1_pulse <= 1'b0;
        end else begin
            cnt_q      <= cnt_d;
            hi_flag    <= hit_hi | (hi_flag & ~flag_clr[0]);
            lo_flag    <= hit_lo | (lo_flag & ~flag_clr[1]);
            zero_pulse <= cfg_r.zero_en && changed && (cnt_d == '0);
            thr0_pulse <= cfg_r.thr0_en && changed && (cnt_d == thresh0);
            thr1_pulse <= cfg_r.thr1_en && changed && (cnt_d == thresh1);
        end
    end
    assign count_o = cnt_q;
endmodule

// File: rtl/pcnt_checker.sv
module pcnt_checker #(
    parameter int CNT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [CNT_W-1:0] count_o,
    input logic signed [CNT_W-1:0] thresh0,
    input logic signed [CNT_W-1:0] thresh1,
    input logic [1:0]              flag_clr,
    input logic                    hi_flag,
    input logic                    lo_flag,
    input logic                    zero_pulse,
    input logic                    thr0_pulse,
    input logic                    thr1_pulse
);
    logic [CNT_W-1:0] prev_cnt;
    logic [CNT_W-1:0] dlt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_cnt <= '0;
        else        prev_cnt <= count_o;
    end
    assign dlt = count_o - prev_cnt;

    // R4: per-clock movement is at most two steps unless the counter returns to zero
    p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != '0) |-> (dlt == '0 || dlt == CNT_W'(1) || dlt == CNT_W'(2) ||
                             dlt == {CNT_W{1'b1}} || dlt == {{(CNT_W-1){1'b1}}, 1'b0}));

    // R7: a fresh high flag coincides with a counter at zero
    p_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_flag) |-> (count_o == '0));

    // R8: a fresh low flag coincides with a counter at zero
    p_lo_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_flag) |-> (count_o == '0));

    // R9: flags are sticky without a clear
    p_hi_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hi_flag) && !$past(flag_clr[0])) |-> hi_flag);
    p_lo_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lo_flag) && !$past(flag_clr[1])) |-> lo_flag);

    // R10: pulses land on the compared value, after a change, for a single cycle
    p_zero_arrive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zero_pulse |-> (count_o == '0 && prev_cnt != '0));
    p_thr0_arrive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        thr0_pulse |-> (count_o == $past(thresh0) && count_o != prev_cnt));
    p_thr1_arrive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        thr1_pulse |-> (count_o == $past(thresh1) && count_o != prev_cnt));
    p_zero_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zero_pulse |=> !zero_pulse);
endmodule

bind pulse_counter_unit pcnt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .count_o(count_o), .thresh0(thresh0), .thresh1(thresh1),
    .flag_clr(flag_clr), .hi_flag(hi_flag), .lo_flag(lo_flag), .zero_pulse(zero_pulse),
    .thr0_pulse(thr0_pulse), .thr1_pulse(thr1_pulse)
);

// File: tb/sim_pulse_counter_unit.sv
`timescale 1ns/1ps
module sim_pulse_counter_unit;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [31:0]        cfg_wdata = '0;
    logic [31:0]        cfg_q;
    logic [1:0]         sig = '0;
    logic [1:0]         ctl = '0;
    logic signed [15:0] hlim = 16'sd1000, llim = -16'sd1000;
    logic signed [15:0] th0 = 16'sd100, th1 = -16'sd100;
    logic               cclr = 1'b0;
    logic [1:0]         fclr = '0;
    logic signed [15:0] count_o;
    logic               hi_flag, lo_flag, zero_pulse, thr0_pulse, thr1_pulse;

    always #10 clk = ~clk;

    pulse_counter_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .sig_in(sig), .ctl_in(ctl), .high_limit(hlim), .low_limit(llim),
        .thresh0(th0), .thresh1(th1), .count_clr(cclr), .flag_clr(fclr),
        .count_o(count_o), .hi_flag(hi_flag), .lo_flag(lo_flag),
        .zero_pulse(zero_pulse), .thr0_pulse(thr0_pulse), .thr1_pulse(thr1_pulse)
    );

    int    n_chk = 0, n_fail = 0;
    string phase = "R1";
    bit    done = 1'b0;
    int    zero_seen = 0, thr0_seen = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_s1[4], m_s2[4], m_lvl[4], m_run[4], m_prev[2];
    logic [31:0] m_cfg;
    int          m_cnt;
    bit          m_hi, m_lo, m_z, m_t0, m_t1;

    function automatic int act_step(int code);
        return (code == 1) ? 1 : (code == 2) ? -1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_lvl[i] = 0; m_run[i] = 0;
            end
            m_prev = '{0, 0};
            m_cfg = 32'h3C10; m_cnt = 0;
            {m_hi, m_lo, m_z, m_t0, m_t1} = '0;
        end else begin
            int net, sum, nxt, te;
            bit hh, hl, zen, hen, len, t0en, t1en;
            int n_lvl[4], n_run[4];
            net = 0;
            for (int c = 0; c < 2; c++) begin
                int b, code, md;
                logic [7:0] cb;
                cb = m_cfg[16 + 8*c +: 8];
                if (m_lvl[c] == 1 && m_prev[c] == 0)      code = cb[3:2];
                else if (m_lvl[c] == 0 && m_prev[c] == 1) code = cb[1:0];
                else                                      code = 0;
                b = act_step(code);
                md = (m_lvl[c+2] != 0) ? cb[5:4] : cb[7:6];
                net += (md == 0) ? b : (md == 1) ? -b : 0;
            end
            zen = m_cfg[11]; hen = m_cfg[12]; len = m_cfg[13]; t0en = m_cfg[14]; t1en = m_cfg[15];
            sum = m_cnt + net;
            hh = !cclr && net != 0 && hen && sum >= int'(hlim);
            hl = !cclr && net != 0 && len && !hh && sum <= int'(llim);
            if (cclr || hh || hl) nxt = 0;
            else begin
                nxt = sum;
                if (nxt > 32767) nxt -= 65536;
                if (nxt < -32768) nxt += 65536;
            end
            m_z  = zen  && nxt != m_cnt && nxt == 0;
            m_t0 = t0en && nxt != m_cnt && nxt == int'(th0);
            m_t1 = t1en && nxt != m_cnt && nxt == int'(th1);
            m_hi = hh || (m_hi && !fclr[0]);
            m_lo = hl || (m_lo && !fclr[1]);
            m_cnt = nxt;
            te = (m_cfg[9:0] == 0) ? 1 : int'(m_cfg[9:0]);
            for (int i = 0; i < 4; i++) begin
                n_lvl[i] = m_lvl[i]; n_run[i] = 0;
                if (!m_cfg[10]) n_lvl[i] = m_s2[i];
                else if (m_s2[i] != m_lvl[i]) begin
                    if (m_run[i] + 1 >= te) n_lvl[i] = m_s2[i];
                    else                    n_run[i] = m_run[i] + 1;
                end
            end
            m_prev[0] = m_lvl[0]; m_prev[1] = m_lvl[1];
            for (int i = 0; i < 4; i++) begin
                m_lvl[i] = n_lvl[i]; m_run[i] = n_run[i];
                m_s2[i]  = m_s1[i];
                m_s1[i]  = (i < 2) ? int'(sig[i]) : int'(ctl[i-2]);
            end
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    // per-clock comparison, away from the active edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk(phase, "count", int'(count_o), m_cnt);
            chk(phase, "flags", int'({hi_flag, lo_flag, zero_pulse, thr0_pulse, thr1_pulse}),
                int'({m_hi, m_lo, m_z, m_t0, m_t1}));
            if (zero_pulse) zero_seen++;
            if (thr0_pulse) thr0_seen++;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [7:0] chb(int fall, int rise, int hm, int lm);
        return {lm[1:0], hm[1:0], rise[1:0], fall[1:0]};
    endfunction

    function automatic logic [31:0] mk(int thr, bit fen, logic [4:0] en, logic [7:0] c0, logic [7:0] c1);
        return {c1, c0, en, fen, thr[9:0]};
    endfunction

    task automatic wr_cfg(logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic spulse(logic [1:0] which, int w, int gap);
        @(negedge clk); sig = sig | which;
        repeat (w) @(negedge clk);
        sig = sig & ~which;
        repeat (gap) @(negedge clk);
    endtask

    task automatic quad(bit a, bit b);
        @(negedge clk); sig = {b, a}; ctl = {a, b};
        repeat (5) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] base_cfg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value
        chk("R1", "cfg reset", int'(cfg_q), 32'h3C10);
        chk("R1", "count reset", int'(count_o), 0);

        // R2 R3 full code sweep on channel 0, filter off
        phase = "R2 R3";
        for (int code = 0; code < 256; code++) begin
            logic [7:0] cb;
            cb = code[7:0];
            wr_cfg(mk(16, 1'b0, 5'b00000, cb, 8'h00));
            for (int lv = 0; lv < 2; lv++) begin
                @(negedge clk); ctl[0] = lv[0];
                repeat (6) @(negedge clk);
                spulse(2'b01, 1, 6);
            end
        end
        @(negedge clk); cclr = 1'b1; @(negedge clk); cclr = 1'b0;

        // R3 inhibit explicitly: rise +1 but high-ctl modifier blocks
        phase = "R3";
        wr_cfg(mk(16, 1'b0, 5'b0, chb(0, 1, 2, 0), 8'h00));
        @(negedge clk); ctl[0] = 1'b1; repeat (6) @(negedge clk);
        spulse(2'b01, 2, 8);
        chk("R3", "blocked step", int'(count_o), 0);
        ctl[0] = 1'b0; repeat (6) @(negedge clk);
        spulse(2'b01, 2, 8);
        chk("R3", "passed step", int'(count_o), 1);

        // R4 simultaneous channels and latency
        phase = "R4";
        wr_cfg(mk(16, 1'b0, 5'b0, chb(0, 1, 0, 0), chb(0, 1, 0, 0)));
        @(negedge clk); sig = 2'b11;
        repeat (3) @(posedge clk);
        #5 chk("R4", "before 4th edge", int'(count_o), 1);
        @(posedge clk); #5 chk("R4", "net +2 at 4th edge", int'(count_o), 3);
        @(negedge clk); sig = 2'b00; repeat (8) @(negedge clk);
        wr_cfg(mk(16, 1'b0, 5'b0, chb(0, 1, 0, 0), chb(0, 2, 0, 0)));
        spulse(2'b11, 2, 8);
        chk("R4", "opposing net 0", int'(count_o), 3);

        // R5 filter boundary, threshold 5
        phase = "R5";
        wr_cfg(mk(5, 1'b1, 5'b0, chb(0, 1, 0, 0), 8'h00));
        spulse(2'b01, 4, 20);
        chk("R5", "narrow pulse rejected", int'(count_o), 3);
        spulse(2'b01, 5, 20);
        chk("R5", "threshold pulse accepted", int'(count_o), 4);
        wr_cfg(mk(0, 1'b1, 5'b0, chb(0, 1, 0, 0), 8'h00));
        spulse(2'b01, 1, 10);
        chk("R5", "threshold 0 acts as 1", int'(count_o), 5);

        // R6 filter disabled with large threshold
        phase = "R6";
        wr_cfg(mk(16, 1'b0, 5'b0, chb(0, 1, 0, 0), 8'h00));
        spulse(2'b01, 1, 10);
        chk("R6", "bypass counts 1-cycle pulse", int'(count_o), 6);
        @(negedge clk); cclr = 1'b1; @(negedge clk); cclr = 1'b0;
        chk("R11", "clear", int'(count_o), 0);

        // R2 R3 quadrature forward and reverse
        phase = "R2 R3 quad";
        wr_cfg(mk(2, 1'b1, 5'b0, chb(2, 1, 0, 1), chb(2, 1, 1, 0)));
        for (int k = 0; k < 3; k++) begin
            quad(1, 0); quad(1, 1); quad(0, 1); quad(0, 0);
        end
        repeat (8) @(negedge clk);
        chk("R2", "quadrature forward", int'(count_o), -12);
        for (int k = 0; k < 3; k++) begin
            quad(0, 1); quad(1, 1); quad(1, 0); quad(0, 0);
        end
        repeat (8) @(negedge clk);
        chk("R3", "quadrature reverse", int'(count_o), 0);

        // R7 R10 high limit with zero and threshold pulses
        phase = "R7 R10";
        @(negedge clk); hlim = 16'sd4; llim = -16'sd4; th0 = 16'sd2;
        base_cfg = mk(16, 1'b0, 5'b01111, chb(0, 1, 0, 0), 8'h00);
        wr_cfg(base_cfg);
        zero_seen = 0; thr0_seen = 0;
        for (int k = 0; k < 4; k++) spulse(2'b01, 1, 8);
        chk("R7", "count reset at high limit", int'(count_o), 0);
        chk("R7", "high flag set", int'(hi_flag), 1);
        chk("R10", "threshold-0 pulses", thr0_seen, 1);
        chk("R10", "zero pulses", zero_seen, 1);
        repeat (5) @(negedge clk);
        chk("R9", "high flag sticky", int'(hi_flag), 1);
        @(negedge clk); fclr = 2'b01; @(negedge clk); fclr = 2'b00;
        chk("R9", "high flag cleared", int'(hi_flag), 0);

        // R8 low limit
        phase = "R8";
        wr_cfg(mk(16, 1'b0, 5'b00111, chb(0, 2, 0, 0), 8'h00));
        for (int k = 0; k < 4; k++) spulse(2'b01, 1, 8);
        chk("R8", "count reset at low limit", int'(count_o), 0);
        chk("R8", "low flag set", int'(lo_flag), 1);
        @(negedge clk); fclr = 2'b10; @(negedge clk); fclr = 2'b00;
        chk("R9", "low flag cleared", int'(lo_flag), 0);

        // R9 set against a held clear: judged by the model each cycle
        phase = "R9";
        wr_cfg(base_cfg);
        @(negedge clk); fclr = 2'b01;
        for (int k = 0; k < 4; k++) spulse(2'b01, 1, 8);
        fclr = 2'b00;
        chk("R9", "held clear leaves flag low", int'(hi_flag), 0);

        // R11 clear coinciding with a limit-reaching step
        phase = "R11";
        for (int k = 0; k < 3; k++) spulse(2'b01, 1, 8);
        @(negedge clk); sig[0] = 1'b1; cclr = 1'b1;
        repeat (6) @(negedge clk);
        cclr = 1'b0; sig[0] = 1'b0; repeat (8) @(negedge clk);
        chk("R11", "clear beats limit: count", int'(count_o), 0);
        chk("R11", "clear beats limit: flag", int'(hi_flag), 0);

        // R12 disabled comparators
        phase = "R12";
        wr_cfg(mk(16, 1'b0, 5'b00000, chb(0, 1, 0, 0), 8'h00));
        zero_seen = 0; thr0_seen = 0;
        for (int k = 0; k < 5; k++) spulse(2'b01, 1, 8);
        chk("R12", "passes disabled limit", int'(count_o), 5);
        chk("R12", "no high flag", int'(hi_flag), 0);
        chk("R12", "no threshold pulse", thr0_seen, 0);
        @(negedge clk); cclr = 1'b1; @(negedge clk); cclr = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12", "no zero pulse", zero_seen, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule